// File: doc/BRIEF.md
# Intermittent Cycle-Steal DMA Throttler

This block is the bus-request side of one DMA channel. Software arms it with a start pulse, a unit count, a unit size and a spacing mode. It then watches an active-low transfer request line. While the line is low it asks an arbiter for the bus. Once the grant arrives it moves exactly one transfer unit and then drops its request, which hands the bus back to the other master. A stand-in data path drives one beat per clock on a 32-bit bus. A 1, 2 or 4-byte unit takes one beat, a 16-byte unit takes four and a 32-byte unit takes eight.

In normal cycle-steal operation the request may be raised again one clock after the bus is returned. The two intermittent settings instead force a quiet window of 16 or 64 bus clocks after each unit before the block may ask again. This keeps the share of bus time taken by DMA low. The channel finishes when its unit count runs out. It then pulses a done flag for one clock and goes idle.

Top module: `dma_cs_throttle`

## Requirements
- R1: While reset is held, and in the first cycle after it, `bus_req`, `beat_valid` and `done` are all low.
- R2: A transfer request is recognised only while `xfer_req_n` is sampled low. While it stays high and no unit is in flight, `bus_req` stays low.
- R3: Once raised, `bus_req` stays high until `bus_gnt` is sampled high. The first beat appears in the cycle after the grant is sampled.
- R4: `unit_size` codes 0, 1 and 2 (1, 2 and 4 bytes) give 1 beat per grant, code 3 (16 bytes) gives 4 beats and code 4 (32 bytes) gives 8 beats. Codes 5 to 7 give 1 beat. `bus_req` stays high through every beat and falls in the cycle after the last one.
- R5: With `mode_sel` 00 or 01 (normal cycle-steal), `bus_req` is low for exactly one cycle between two units of a job when the request line stays low.
- R6: With `mode_sel` 10, `bus_req` is low for exactly 16 cycles between two units of a job when the request line stays low.
- R7: With `mode_sel` 11, `bus_req` is low for exactly 64 cycles between two units of a job when the request line stays low.
- R8: If `xfer_req_n` is high when the quiet window ends, the block waits. `bus_req` rises in the cycle after `xfer_req_n` is first sampled low.
- R9: After `xfer_count` units, `done` is high for exactly one cycle. That cycle follows the last beat, `bus_req` is low in it, and the block goes idle.
- R10: A start with `xfer_count` equal to 0 pulses `done` in the next cycle and never raises `bus_req`.
- R11: A start pulse while a job is in progress is ignored. The running job still ends after its own count.
- R12: `mode_sel`, `unit_size` and `xfer_count` are captured at the accepted start. Later changes do not alter the running job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also the clock that counts the quiet window |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that arms a job when idle |
| mode_sel | input | 2 | 00/01 normal, 10 quiet window of 16, 11 quiet window of 64 |
| unit_size | input | 3 | Unit size code: 0=1B, 1=2B, 2=4B, 3=16B, 4=32B |
| xfer_count | input | CNT_W | Number of units in the job |
| xfer_req_n | input | 1 | Transfer request, active low, level sensitive |
| bus_req | output | 1 | Request for bus ownership, held through a unit |
| bus_gnt | input | 1 | Grant from the arbiter |
| beat_valid | output | 1 | One data beat on the bus this cycle |
| done | output | 1 | One-cycle pulse when the job's last unit ends |

## Verification
The properties assume an arbiter that raises `bus_gnt` only while `bus_req` is high and keeps it high until the request drops. They also assume that every input is synchronous to `clk`. The bench's arbiter model grants after a chosen number of cycles of seen request and withdraws the grant as soon as the request falls. All inputs change only on the falling edge. Stimulus covers request lines held low, lifted before a job and lifted during a quiet window, as well as configuration changes in the middle of a job.

// File: rtl/dma_cs_pkg.sv
// Shared definitions for the cycle-steal throttler.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dma_cs_pkg;

    // Controller phases.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_REQ   = 3'd2,
        ST_XFER  = 3'd3,
        ST_GAP   = 3'd4
    } dma_state_e;

    // Unit size codes.
    localparam logic [2:0] SZ_1B  = 3'd0;
    localparam logic [2:0] SZ_2B  = 3'd1;
    localparam logic [2:0] SZ_4B  = 3'd2;
    localparam logic [2:0] SZ_16B = 3'd3;
    localparam logic [2:0] SZ_32B = 3'd4;

    // Bit positions inside the mode field.
    localparam int MODE_SPACED_BIT = 1;
    localparam int MODE_LONG_BIT   = 0;

endpackage

// File: rtl/dma_down_ctr.sv
// Loadable down counter that stops at zero.
// A load takes priority over a decrement, and a decrement at zero is ignored.
// Assumes: synchronous active-low reset clears the count.
module dma_down_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count
);

    // Count register: reset, load or decrement towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec && (count != '0)) begin
            count <= count - W'(1);
        end
    end

endmodule

// File: rtl/dma_unit_sizer.sv
// Maps a unit size code to the number of bus beats minus one.
// Codes with no defined size are treated as one bus word.
// Assumes: MAX_UNIT is a multiple of BUS_BYTES.
module dma_unit_sizer
    import dma_cs_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int MAX_UNIT  = 32,
    localparam int BEATS_MAX = MAX_UNIT / BUS_BYTES,
    localparam int BEAT_W    = (BEATS_MAX > 1) ? $clog2(BEATS_MAX) : 1
) (
    input  logic [2:0]        size_code,
    output logic [BEAT_W-1:0] beats_m1
);

    int unit_bytes;
    int beat_total;

    // Decode the code to a byte count.
    always_comb begin
        unique case (size_code)
            SZ_1B:   unit_bytes = 1;
            SZ_2B:   unit_bytes = 2;
            SZ_4B:   unit_bytes = 4;
            SZ_16B:  unit_bytes = 16;
            SZ_32B:  unit_bytes = 32;
            default: unit_bytes = BUS_BYTES;
        endcase
    end

    // Convert bytes to beats, rounding a sub-word unit up to one beat.
    always_comb begin
        beat_total = (unit_bytes + BUS_BYTES - 1) / BUS_BYTES;
        if (beat_total < 1) begin
            beat_total = 1;
        end
        beats_m1 = BEAT_W'(beat_total - 1);
    end

endmodule

// File: rtl/dma_gap_sel.sv
// Chooses the reload value of the quiet-window counter.
// Two window lengths are supported. When both are equal, a single constant is produced.
// Assumes: GAP_SHORT and GAP_LONG are both at least 1 and GAP_SHORT <= GAP_LONG.
module dma_gap_sel #(
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64,
    localparam int GAP_W    = (GAP_LONG > 1) ? $clog2(GAP_LONG) : 1
) (
    input  logic             long_sel,
    output logic [GAP_W-1:0] reload
);

    generate
        if (GAP_SHORT == GAP_LONG) begin : g_single
            logic unused_sel;
            // Only one window length exists, so the select does nothing.
            assign unused_sel = long_sel;
            assign reload     = GAP_W'(GAP_LONG - 1);
        end else begin : g_pair
            // Pick one of the two window lengths.
            assign reload = long_sel ? GAP_W'(GAP_LONG - 1) : GAP_W'(GAP_SHORT - 1);
        end
    endgenerate

endmodule

// File: rtl/dma_cs_throttle.sv
// Single-channel cycle-steal bus-request controller with optional quiet windows.
// A job arms on start, requests the bus while the active-low request line
// is low, moves one unit per grant and releases the bus. In spaced modes it
// stays quiet for a fixed number of clocks before it asks again.
// Assumes: all inputs are synchronous to clk, and the arbiter holds bus_gnt
// for as long as bus_req stays high.
module dma_cs_throttle
    import dma_cs_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BUS_BYTES = 4,
    parameter int MAX_UNIT  = 32,
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64,
    localparam int BEATS_MAX = MAX_UNIT / BUS_BYTES,
    localparam int BEAT_W    = (BEATS_MAX > 1) ? $clog2(BEATS_MAX) : 1,
    localparam int GAP_W     = (GAP_LONG > 1) ? $clog2(GAP_LONG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode_sel,
    input  logic [2:0]       unit_size,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             xfer_req_n,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             beat_valid,
    output logic             done
);

    dma_state_e        state_q;
    dma_state_e        state_d;
    logic              spaced_q;
    logic              long_q;
    logic [2:0]        size_q;
    logic              done_q;

    logic [CNT_W-1:0]  units_left;
    logic [BEAT_W-1:0] beats_left;
    logic [GAP_W-1:0]  gap_left;
    logic [BEAT_W-1:0] beats_m1;
    logic [GAP_W-1:0]  gap_reload;

    logic              accept;
    logic              zero_job;
    logic              unit_end;
    logic              last_unit;
    logic              req_seen;
    logic              gap_over;
    logic              gnt_take;

    // Qualifying terms shared by the counters and the phase logic.
    always_comb begin
        accept    = (state_q == ST_IDLE) && start;
        zero_job  = (xfer_count == '0);
        unit_end  = (state_q == ST_XFER) && (beats_left == '0);
        last_unit = (units_left == CNT_W'(1));
        req_seen  = !xfer_req_n;
        gap_over  = (state_q == ST_GAP) && (gap_left == '0);
        gnt_take  = (state_q == ST_REQ) && bus_gnt;
    end

    // Size code of the captured job to beat count.
    dma_unit_sizer #(
        .BUS_BYTES (BUS_BYTES),
        .MAX_UNIT  (MAX_UNIT)
    ) sizer_i (
        .size_code (size_q),
        .beats_m1  (beats_m1)
    );

    // Quiet-window length for the captured mode.
    dma_gap_sel #(
        .GAP_SHORT (GAP_SHORT),
        .GAP_LONG  (GAP_LONG)
    ) gap_sel_i (
        .long_sel (long_q),
        .reload   (gap_reload)
    );

    // Units still to move in this job.
    dma_down_ctr #(.W(CNT_W)) unit_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (xfer_count),
        .dec      (unit_end),
        .count    (units_left)
    );

    // Beats still to move in the current unit.
    dma_down_ctr #(.W(BEAT_W)) beat_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gnt_take),
        .load_val (beats_m1),
        .dec      (state_q == ST_XFER),
        .count    (beats_left)
    );

    // Clocks left in the quiet window after a unit.
    dma_down_ctr #(.W(GAP_W)) gap_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (unit_end && !last_unit && spaced_q),
        .load_val (gap_reload),
        .dec      (state_q == ST_GAP),
        .count    (gap_left)
    );

    // Capture the job configuration on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spaced_q <= 1'b0;
            long_q   <= 1'b0;
            size_q   <= SZ_1B;
        end else if (accept) begin
            spaced_q <= mode_sel[MODE_SPACED_BIT];
            long_q   <= mode_sel[MODE_LONG_BIT];
            size_q   <= unit_size;
        end
    end

    // Next-phase decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !zero_job) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (req_seen) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    state_d = ST_XFER;
                end
            end
            ST_XFER: begin
                if (unit_end) begin
                    if (last_unit) begin
                        state_d = ST_IDLE;
                    end else if (spaced_q) begin
                        state_d = ST_GAP;
                    end else begin
                        state_d = ST_ARMED;
                    end
                end
            end
            ST_GAP: begin
                if (gap_over) begin
                    state_d = req_seen ? ST_REQ : ST_ARMED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (accept && zero_job) || (unit_end && last_unit);
        end
    end

    // Outputs decoded from registered state only.
    always_comb begin
        bus_req    = (state_q == ST_REQ) || (state_q == ST_XFER);
        beat_valid = (state_q == ST_XFER);
        done       = done_q;
    end

endmodule

// File: rtl/dma_cs_throttle_chk.sv
// Property checker for the cycle-steal throttler, attached by bind.
// It tracks job activity and quiet-window lengths from the ports and from
// the captured mode bits.
// Assumes: the arbiter grants only while bus_req is high.
module dma_cs_throttle_chk #(
    parameter int CNT_W     = 16,
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] xfer_count,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             beat_valid,
    input logic             done,
    input logic             spaced,
    input logic             long_sel
);

    int   low_run;
    logic mid_job;
    logic job_on;

    // Length of the current run of clocks with bus_req low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= 0;
        end else if (bus_req) begin
            low_run <= 0;
        end else if (low_run < 100000) begin
            low_run <= low_run + 1;
        end
    end

    // Set between units of one job, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_job <= 1'b0;
        end else if (done) begin
            mid_job <= 1'b0;
        end else if (!bus_req && beat_valid == 1'b0 && $past(beat_valid)) begin
            mid_job <= 1'b1;
        end
    end

    // Tracks whether a job with units is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_on <= 1'b0;
        end else if (done) begin
            job_on <= 1'b0;
        end else if (start && (xfer_count != '0)) begin
            job_on <= 1'b1;
        end
    end

    // R3: a pending request is held until it is granted.
    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !beat_valid && !bus_gnt) |=> (bus_req && !beat_valid));

    // R3: beats only start after a sampled grant.
    assert_beat_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid) |-> $past(bus_gnt));

    // R4: the bus is owned during every beat.
    assert_beat_owns_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> bus_req);

    // R9: done comes with the bus released and lasts one cycle.
    assert_done_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R6 and R7: in a spaced mode, the quiet window is respected between units.
    assert_gap_window_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_req) && mid_job && spaced) |->
            (low_run >= (long_sel ? GAP_LONG : GAP_SHORT)));

    // R10: an empty job completes at once.
    assert_zero_job_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !job_on && (xfer_count == '0)) |=> done);

endmodule

bind dma_cs_throttle dma_cs_throttle_chk #(
    .CNT_W     (CNT_W),
    .GAP_SHORT (GAP_SHORT),
    .GAP_LONG  (GAP_LONG)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .xfer_count (xfer_count),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .beat_valid (beat_valid),
    .done       (done),
    .spaced     (spaced_q),
    .long_sel   (long_q)
);

// File: tb/dma_cs_throttle_tb_top.sv
`timescale 1ns/1ps
module dma_cs_throttle_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       mode_sel = 2'b00;
    logic [2:0]       unit_size = 3'd0;
    logic [CNT_W-1:0] xfer_count = '0;
    logic             xfer_req_n = 1'b1;
    logic             bus_req;
    logic             bus_gnt = 1'b0;
    logic             beat_valid;
    logic             done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int gnt_delay = 0;
    int gnt_wait = 0;
    bit finished = 0;

    int gapq[$];
    int beatq[$];
    int done_seen = 0;
    int gap_run = 0;
    bit gap_on = 0;
    int beat_run = 0;
    logic prev_req = 1'b0;

    // Reference model state.
    int  m_ph = 0;
    int  m_units = 0;
    int  m_nb = 1;
    int  m_bl = 0;
    int  m_gl = 0;
    bit  m_sp = 0;
    bit  m_lg = 0;
    bit  m_done = 0;

    always #2 clk = ~clk;

    dma_cs_throttle #(.CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_sel   (mode_sel),
        .unit_size  (unit_size),
        .xfer_count (xfer_count),
        .xfer_req_n (xfer_req_n),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .beat_valid (beat_valid),
        .done       (done)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_list(input int q[$], input int n, input int v,
                            input string rq, input string what);
        chk(q.size() == n, rq, {what, " count"}, q.size(), n);
        foreach (q[i]) chk(q[i] == v, rq, what, q[i], v);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Beats per unit from the requirement's size table (R4).
    function automatic int beats_for(input logic [2:0] code);
        case (code)
            3'd3:    return 4;
            3'd4:    return 8;
            default: return 1;
        endcase
    endfunction

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        bit nd;
        nd = 0;
        if (!rst_n) begin
            m_ph = 0; m_units = 0; m_bl = 0; m_gl = 0;
        end else begin
            case (m_ph)
                0: if (start) begin
                       if (xfer_count == 0) nd = 1;
                       else begin
                           m_units = int'(xfer_count);
                           m_sp = mode_sel[1];
                           m_lg = mode_sel[0];
                           m_nb = beats_for(unit_size);
                           m_ph = 1;
                       end
                   end
                1: if (!xfer_req_n) m_ph = 2;
                2: if (bus_gnt) begin m_bl = m_nb; m_ph = 3; end
                3: begin
                       m_bl--;
                       if (m_bl == 0) begin
                           m_units--;
                           if (m_units == 0) begin nd = 1; m_ph = 0; end
                           else if (m_sp) begin m_gl = m_lg ? 64 : 16; m_ph = 4; end
                           else m_ph = 1;
                       end
                   end
                4: begin
                       m_gl--;
                       if (m_gl == 0) m_ph = xfer_req_n ? 1 : 2;
                   end
                default: m_ph = 0;
            endcase
        end
        m_done = nd;
    end

    // Arbiter model: grant after a delay, withdraw when the request drops.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req) begin
                if (gnt_wait >= gnt_delay) bus_gnt = 1'b1;
                else gnt_wait++;
            end else begin
                bus_gnt = 1'b0;
                gnt_wait = 0;
            end
        end
    end

    // Lockstep compare and run-length monitors.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(bus_req == ((m_ph == 2) || (m_ph == 3)), "R3", "bus_req vs model",
                bus_req, (m_ph == 2) || (m_ph == 3));
            chk(beat_valid == (m_ph == 3), "R4", "beat_valid vs model",
                beat_valid, m_ph == 3);
            chk(done == m_done, "R9", "done vs model", done, m_done);
            if (done) done_seen++;
            if (beat_valid) beat_run++;
            else if (beat_run > 0) begin beatq.push_back(beat_run); beat_run = 0; end
            if (prev_req && !bus_req && !done) begin gap_on = 1; gap_run = 1; end
            else if (gap_on && !bus_req) gap_run++;
            else if (gap_on && bus_req) begin gapq.push_back(gap_run); gap_on = 0; end
            prev_req = bus_req;
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(0, "R9", "watchdog expired", cyc, 150000);
                finish_run();
            end
        end
    end

    task automatic clear_obs();
        gapq.delete();
        beatq.delete();
        done_seen = 0;
    endtask

    task automatic start_job(input logic [1:0] m, input logic [2:0] s, input int n);
        @(negedge clk);
        mode_sel = m; unit_size = s; xfer_count = CNT_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state.
        repeat (4) @(negedge clk);
        chk(bus_req == 0 && beat_valid == 0 && done == 0, "R1", "outputs in reset",
            {bus_req, beat_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req == 0 && beat_valid == 0 && done == 0, "R1", "outputs after reset",
            {bus_req, beat_valid, done}, 0);

        // R5: mode 00, word units, grant delay 2.
        xfer_req_n = 1'b0; gnt_delay = 2; clear_obs();
        start_job(2'b00, 3'd2, 3); wait_done();
        chk_list(beatq, 3, 1, "R4", "beats of 4B unit");
        chk_list(gapq, 2, 1, "R5", "release gap mode 00");
        chk(done_seen == 1, "R9", "done pulses", done_seen, 1);

        // R5 with mode 01, 16-byte units.
        gnt_delay = 0; clear_obs();
        start_job(2'b01, 3'd3, 2); wait_done();
        chk_list(beatq, 2, 4, "R4", "beats of 16B unit");
        chk_list(gapq, 1, 1, "R5", "release gap mode 01");

        // R6: mode 10, 32-byte units.
        gnt_delay = 1; clear_obs();
        start_job(2'b10, 3'd4, 3); wait_done();
        chk_list(beatq, 3, 8, "R4", "beats of 32B unit");
        chk_list(gapq, 2, 16, "R6", "quiet window mode 10");

        // R7: mode 11, byte units.
        gnt_delay = 3; clear_obs();
        start_job(2'b11, 3'd0, 2); wait_done();
        chk_list(beatq, 2, 1, "R4", "beats of 1B unit");
        chk_list(gapq, 1, 64, "R7", "quiet window mode 11");

        // R2 and R8: request line high before the job and during a window.
        gnt_delay = 0; clear_obs(); xfer_req_n = 1'b1;
        start_job(2'b10, 3'd1, 2);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(bus_req == 0, "R2", "no request while line high", bus_req, 0);
        end
        xfer_req_n = 1'b0;
        while (!beat_valid) @(negedge clk);
        xfer_req_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(bus_req == 0, "R2", "no request in window or line high", bus_req, 0);
        end
        xfer_req_n = 1'b0;
        @(negedge clk);
        chk(bus_req == 1, "R8", "request follows late line", bus_req, 1);
        wait_done();
        chk_list(gapq, 1, 40, "R8", "stretched window");

        // R10: empty job.
        clear_obs();
        start_job(2'b00, 3'd0, 0);
        chk(done == 1, "R10", "done for empty job", done, 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(bus_req == 0 && done == 0, "R10", "quiet after empty job",
                {bus_req, done}, 0);
        end

        // R11 and R12: restart and reconfigure mid-job.
        gnt_delay = 1; clear_obs();
        start_job(2'b00, 3'd2, 3);
        while (!beat_valid) @(negedge clk);
        mode_sel = 2'b11; unit_size = 3'd4; xfer_count = CNT_W'(9); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk_list(beatq, 3, 1, "R12", "size kept after change");
        chk_list(gapq, 2, 1, "R12", "mode kept after change");
        chk(done_seen == 1, "R11", "restart ignored", done_seen, 1);

        // R4: reserved size code.
        gnt_delay = 0; clear_obs();
        start_job(2'b00, 3'd6, 2); wait_done();
        chk_list(beatq, 2, 1, "R4", "beats of reserved code");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule